// File: doc/BRIEF.md
# Page-Level Access Counter Classifier

This block sits next to a shared last-level cache and watches the physical addresses of accesses that missed in the first-level caches. It keeps per-page read, write and total counts in two small set-associative counter stores with the same number of sets. The "nursery" store takes pages seen for the first time. The "mature" store holds pages that have proved hotter than their neighbours in the same set. A sampler in front of the stores lets through only one access in every N. The remaining accesses leave no trace.

Software drives three control actions. A swap pulse starts a walk over all sets, one set per cycle. In each set the busiest nursery entry may trade places with the quietest mature entry. An age pulse halves every counter in a single cycle. Software reads the stores through a combinational scan port addressed by store, set and way. The scan port flags an entry as hot when its total count reaches a programmable threshold.

The access input is a valid/ready stream with no output side. The block lowers `acc_ready` while a walk is running, and also in any cycle where a swap or age pulse is present. A beat is accepted only when valid and ready are both high. The source must hold the beat until it is accepted. A beat that is not accepted changes no counter and does not advance the sampler.

Top module: `pcc_classifier`

## Requirements
- R1: The page number begins at address bit 12. The set index is the SET_BITS bits starting at bit 12, and the tag is every address bit above the set index. Bits 11..0 have no effect.
- R2: An accepted, sampled access that hits a valid entry in either store adds one to its write counter when `acc_write`=1, or to its read counter when `acc_write`=0. The same access also adds one to the total counter.
- R3: An accepted, sampled access that misses both stores overwrites one nursery entry of its set. The victim is the way with the smallest total; an invalid way counts as 0, and the lowest way wins a tie. The new entry is valid, carries the new tag, and has total=1. Its read counter is 1 for a read (0 for a write), and its write counter is 1 for a write (0 for a read).
- R4: Every counter saturates at 2^CNT_W-1. The total counter is never below the read counter or the write counter.
- R5: With `sample_div` at 0 or 1, every accepted access is counted. With a value N>1, the first accepted access after reset is counted, then every Nth accepted access after it. Skipped accesses change no entry.
- R6: A `swap_start` pulse while idle raises `busy` from the next cycle for exactly 2^SET_BITS cycles. During that time the sets are visited in ascending order, one per cycle. A `swap_start` pulse has priority over `age_start`.
- R7: In each visited set, the nursery way with the largest total (lowest way on a tie) is compared with the mature way with the smallest total (lowest way on a tie). Invalid ways count as 0. The two entries exchange all their fields only if the nursery total is strictly larger.
- R8: An `age_start` pulse while idle shifts every read, write and total counter right by one bit in one cycle. Valid bits and tags are unchanged. An `age_start` pulse while `busy` is high is ignored.
- R9: `acc_ready` is low while `busy` is high or while `swap_start` or `age_start` is high. An access that is not accepted is not counted.
- R10: The scan outputs show the entry selected by `scan_store` (0 = nursery, 1 = mature), `scan_set` and `scan_way` in the same cycle. `scan_hot` is 1 exactly when that entry is valid and its total is at least `hot_thresh`.
- R11: After reset every entry is invalid with all counters 0, `busy` is low and the sampler counts the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access beat present |
| acc_ready | output | 1 | Block can take an access this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W | Physical address of the access |
| sample_div | input | DIV_W | Sampling divisor N (0 and 1 count every access) |
| hot_thresh | input | CNT_W | Total count at which a scanned entry is hot |
| swap_start | input | 1 | Pulse: start a promotion walk over all sets |
| age_start | input | 1 | Pulse: halve all counters |
| busy | output | 1 | Promotion walk in progress |
| scan_store | input | 1 | Scan store select, 0 nursery, 1 mature |
| scan_set | input | SET_BITS | Scan set index |
| scan_way | input | WAY_BITS | Scan way index |
| scan_valid | output | 1 | Scanned entry valid |
| scan_tag | output | ADDR_W-12-SET_BITS | Scanned entry tag |
| scan_rd | output | CNT_W | Scanned entry read count |
| scan_wr | output | CNT_W | Scanned entry write count |
| scan_tot | output | CNT_W | Scanned entry total count |
| scan_hot | output | 1 | Scanned entry reaches hot_thresh |

## Verification
The counting path is tried in several ways:
- The same page is reached again through a different page offset.
- The same tag is used in a different set.
- A set is filled until a least-count victim must be chosen.
- One page is hit repeatedly past the counter ceiling.

These separate address slicing from victim choice and from saturation. A divisor of three shows that skipped beats leave the stores untouched. Three promotion walks cover an empty mature slot, a strictly larger nursery count, and an equal count that must not move. An age pulse is tried once while idle and once during a walk, together with a stalled access, so that the ignored-while-busy rules are seen at the scan port. A behavioural model is compared every cycle while the scan address rotates over all entries.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  // Page granule: the page number starts at this address bit.
  localparam int PAGE_SHIFT = 12;
  // Store indices inside the counter arrays.
  localparam int ST_YOUNG = 0;
  localparam int ST_OLD   = 1;
endpackage

// File: rtl/pcc_sampler.sv
module pcc_sampler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DIV_W-1:0] div,
  output logic             fire
);
  logic [DIV_W-1:0] phase_q;
  logic             every;
  logic [DIV_W:0]   nxt;

  assign every = (div <= DIV_W'(1));
  assign fire  = every || (phase_q == '0);
  assign nxt   = {1'b0, phase_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (take)
      phase_q <= (every || nxt >= {1'b0, div}) ? '0 : nxt[DIV_W-1:0];
  end

  // A counted beat under a divisor above one is followed by skipped ones.
  p_skip_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fire && div > DIV_W'(1)) |=> (div <= DIV_W'(1) || !fire));
endmodule

// File: rtl/pcc_pick.sv
module pcc_pick #(
  parameter int WAY_BITS = 1,
  parameter int CNT_W    = 6,
  parameter bit FIND_MAX = 1'b0
) (
  input  logic [(1<<WAY_BITS)-1:0]       vld,
  input  logic [(1<<WAY_BITS)*CNT_W-1:0] cnt,
  output logic [WAY_BITS-1:0]            idx
);
  localparam int WAYS = 1 << WAY_BITS;

  function automatic logic [CNT_W-1:0] eff(input int w);
    return vld[w] ? cnt[w*CNT_W +: CNT_W] : '0;
  endfunction

  logic [CNT_W-1:0] best;

  if (FIND_MAX) begin : g_max
    always_comb begin
      best = eff(0);
      idx  = '0;
      for (int w = 1; w < WAYS; w++)
        if (eff(w) > best) begin
          best = eff(w);
          idx  = WAY_BITS'(w);
        end
    end
  end else begin : g_min
    always_comb begin
      best = eff(0);
      idx  = '0;
      for (int w = 1; w < WAYS; w++)
        if (eff(w) < best) begin
          best = eff(w);
          idx  = WAY_BITS'(w);
        end
    end
  end
endmodule

// File: rtl/pcc_classifier.sv
module pcc_classifier
  import pcc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 2,
  parameter int WAY_BITS = 1,
  parameter int CNT_W    = 6,
  parameter int DIV_W    = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             acc_valid,
  output logic                             acc_ready,
  input  logic                             acc_write,
  input  logic [ADDR_W-1:0]                acc_addr,
  input  logic [DIV_W-1:0]                 sample_div,
  input  logic [CNT_W-1:0]                 hot_thresh,
  input  logic                             swap_start,
  input  logic                             age_start,
  output logic                             busy,
  input  logic                             scan_store,
  input  logic [SET_BITS-1:0]              scan_set,
  input  logic [WAY_BITS-1:0]              scan_way,
  output logic                             scan_valid,
  output logic [ADDR_W-PAGE_SHIFT-SET_BITS-1:0] scan_tag,
  output logic [CNT_W-1:0]                 scan_rd,
  output logic [CNT_W-1:0]                 scan_wr,
  output logic [CNT_W-1:0]                 scan_tot,
  output logic                             scan_hot
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int WAYS  = 1 << WAY_BITS;
  localparam int TAG_W = ADDR_W - PAGE_SHIFT - SET_BITS;

  // Entry storage: [store][set][way]
  logic             vld_q [2][SETS][WAYS];
  logic [TAG_W-1:0] tag_q [2][SETS][WAYS];
  logic [CNT_W-1:0] rd_q  [2][SETS][WAYS];
  logic [CNT_W-1:0] wr_q  [2][SETS][WAYS];
  logic [CNT_W-1:0] tot_q [2][SETS][WAYS];

  logic                busy_q;
  logic [SET_BITS-1:0] wset_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  // Lookup side
  logic [SET_BITS-1:0] set_a;
  logic [TAG_W-1:0]    tag_a;
  logic [WAYS-1:0]     hit_old, hit_yng;
  logic [WAY_BITS-1:0] hw_old, hw_yng, victim;
  logic                accept, fire, count_it, is_new;
  logic                tgt_st;
  logic [WAY_BITS-1:0] tgt_way;

  assign set_a     = acc_addr[PAGE_SHIFT +: SET_BITS];
  assign tag_a     = acc_addr[ADDR_W-1 -: TAG_W];
  assign acc_ready = !busy_q && !swap_start && !age_start;
  assign accept    = acc_valid && acc_ready;
  assign count_it  = accept && fire;
  assign busy      = busy_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_hit
    assign hit_old[w] = vld_q[ST_OLD][set_a][w]   && tag_q[ST_OLD][set_a][w]   == tag_a;
    assign hit_yng[w] = vld_q[ST_YOUNG][set_a][w] && tag_q[ST_YOUNG][set_a][w] == tag_a;
  end

  always_comb begin
    hw_old = '0;
    hw_yng = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_old[w]) hw_old = WAY_BITS'(w);
      if (hit_yng[w]) hw_yng = WAY_BITS'(w);
    end
  end

  assign is_new  = !(|hit_old) && !(|hit_yng);
  assign tgt_st  = |hit_old;
  assign tgt_way = (|hit_old) ? hw_old : (|hit_yng) ? hw_yng : victim;

  pcc_sampler #(.DIV_W(DIV_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .take(accept), .div(sample_div), .fire(fire)
  );

  // Flattened views for the way pickers
  logic [WAYS-1:0]       ins_vld, wy_vld, wo_vld;
  logic [WAYS*CNT_W-1:0] ins_cnt, wy_cnt, wo_cnt;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      ins_vld[w]              = vld_q[ST_YOUNG][set_a][w];
      ins_cnt[w*CNT_W +: CNT_W] = tot_q[ST_YOUNG][set_a][w];
      wy_vld[w]               = vld_q[ST_YOUNG][wset_q][w];
      wy_cnt[w*CNT_W +: CNT_W]  = tot_q[ST_YOUNG][wset_q][w];
      wo_vld[w]               = vld_q[ST_OLD][wset_q][w];
      wo_cnt[w*CNT_W +: CNT_W]  = tot_q[ST_OLD][wset_q][w];
    end
  end

  logic [WAY_BITS-1:0] y_max, o_min;

  pcc_pick #(.WAY_BITS(WAY_BITS), .CNT_W(CNT_W), .FIND_MAX(1'b0)) u_victim (
    .vld(ins_vld), .cnt(ins_cnt), .idx(victim));
  pcc_pick #(.WAY_BITS(WAY_BITS), .CNT_W(CNT_W), .FIND_MAX(1'b1)) u_ymax (
    .vld(wy_vld), .cnt(wy_cnt), .idx(y_max));
  pcc_pick #(.WAY_BITS(WAY_BITS), .CNT_W(CNT_W), .FIND_MAX(1'b0)) u_omin (
    .vld(wo_vld), .cnt(wo_cnt), .idx(o_min));

  logic [CNT_W-1:0] y_best, o_best;
  logic             do_swap;
  assign y_best  = wy_vld[y_max] ? tot_q[ST_YOUNG][wset_q][y_max] : '0;
  assign o_best  = wo_vld[o_min] ? tot_q[ST_OLD][wset_q][o_min]   : '0;
  assign do_swap = busy_q && (y_best > o_best);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wset_q <= '0;
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) begin
            vld_q[k][s][w] <= 1'b0;
            tag_q[k][s][w] <= '0;
            rd_q[k][s][w]  <= '0;
            wr_q[k][s][w]  <= '0;
            tot_q[k][s][w] <= '0;
          end
    end else if (busy_q) begin
      if (do_swap) begin
        vld_q[ST_YOUNG][wset_q][y_max] <= vld_q[ST_OLD][wset_q][o_min];
        tag_q[ST_YOUNG][wset_q][y_max] <= tag_q[ST_OLD][wset_q][o_min];
        rd_q[ST_YOUNG][wset_q][y_max]  <= rd_q[ST_OLD][wset_q][o_min];
        wr_q[ST_YOUNG][wset_q][y_max]  <= wr_q[ST_OLD][wset_q][o_min];
        tot_q[ST_YOUNG][wset_q][y_max] <= tot_q[ST_OLD][wset_q][o_min];
        vld_q[ST_OLD][wset_q][o_min]   <= vld_q[ST_YOUNG][wset_q][y_max];
        tag_q[ST_OLD][wset_q][o_min]   <= tag_q[ST_YOUNG][wset_q][y_max];
        rd_q[ST_OLD][wset_q][o_min]    <= rd_q[ST_YOUNG][wset_q][y_max];
        wr_q[ST_OLD][wset_q][o_min]    <= wr_q[ST_YOUNG][wset_q][y_max];
        tot_q[ST_OLD][wset_q][o_min]   <= tot_q[ST_YOUNG][wset_q][y_max];
      end
      if (wset_q == SET_BITS'(SETS-1)) busy_q <= 1'b0;
      wset_q <= wset_q + 1'b1;
    end else if (swap_start) begin
      busy_q <= 1'b1;
      wset_q <= '0;
    end else if (age_start) begin
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) begin
            rd_q[k][s][w]  <= rd_q[k][s][w]  >> 1;
            wr_q[k][s][w]  <= wr_q[k][s][w]  >> 1;
            tot_q[k][s][w] <= tot_q[k][s][w] >> 1;
          end
    end else if (count_it) begin
      if (is_new) begin
        vld_q[ST_YOUNG][set_a][victim] <= 1'b1;
        tag_q[ST_YOUNG][set_a][victim] <= tag_a;
        rd_q[ST_YOUNG][set_a][victim]  <= acc_write ? '0 : CNT_W'(1);
        wr_q[ST_YOUNG][set_a][victim]  <= acc_write ? CNT_W'(1) : '0;
        tot_q[ST_YOUNG][set_a][victim] <= CNT_W'(1);
      end else begin
        if (acc_write) wr_q[tgt_st][set_a][tgt_way] <= sat_inc(wr_q[tgt_st][set_a][tgt_way]);
        else           rd_q[tgt_st][set_a][tgt_way] <= sat_inc(rd_q[tgt_st][set_a][tgt_way]);
        tot_q[tgt_st][set_a][tgt_way] <= sat_inc(tot_q[tgt_st][set_a][tgt_way]);
      end
    end
  end

  // Scan read-out
  assign scan_valid = vld_q[scan_store][scan_set][scan_way];
  assign scan_tag   = tag_q[scan_store][scan_set][scan_way];
  assign scan_rd    = rd_q[scan_store][scan_set][scan_way];
  assign scan_wr    = wr_q[scan_store][scan_set][scan_way];
  assign scan_tot   = tot_q[scan_store][scan_set][scan_way];
  assign scan_hot   = scan_valid && (scan_tot >= hot_thresh);

  // Checks
  p_stall_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !acc_ready);
  p_walk_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wset_q == SET_BITS'(SETS-1)) |=> !busy_q);
  p_walk_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(swap_start) && wset_q == '0));
  p_single_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_old, hit_yng}));
  p_age_idle_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && age_start) |=> $stable(vld_q[ST_OLD][0][0]) && $stable(tag_q[ST_OLD][0][0]));

  for (genvar k = 0; k < 2; k++) begin : g_ck
    for (genvar s = 0; s < SETS; s++) begin : g_cs
      for (genvar w = 0; w < WAYS; w++) begin : g_cw
        p_total_covers_r4: assert property (@(posedge clk) disable iff (!rst_n)
          tot_q[k][s][w] >= rd_q[k][s][w] && tot_q[k][s][w] >= wr_q[k][s][w]);
      end
    end
  end
endmodule

// File: tb/pcc_classifier_tb_top.sv
`timescale 1ns/1ps
module pcc_classifier_tb_top;
  localparam int SB = 2, WB = 1, CW = 6, DW = 4, AW = 32;
  localparam int SETS = 4, WAYS = 2, TAGW = AW - 12 - SB, MAXC = 63;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, swap_start = 0, age_start = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] sample_div = 4'd1;
  logic [CW-1:0] hot_thresh = 6'd3;
  logic scan_store = 0;
  logic [SB-1:0] scan_set = '0;
  logic [WB-1:0] scan_way = '0;
  logic acc_ready, busy, scan_valid, scan_hot;
  logic [TAGW-1:0] scan_tag;
  logic [CW-1:0] scan_rd, scan_wr, scan_tot;

  always #2.5 clk = ~clk;

  pcc_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .sample_div(sample_div),
    .hot_thresh(hot_thresh), .swap_start(swap_start), .age_start(age_start),
    .busy(busy), .scan_store(scan_store), .scan_set(scan_set), .scan_way(scan_way),
    .scan_valid(scan_valid), .scan_tag(scan_tag), .scan_rd(scan_rd),
    .scan_wr(scan_wr), .scan_tot(scan_tot), .scan_hot(scan_hot));

  int vectors = 0, fails = 0;
  bit done_f = 0, hold = 0;
  int si = 0;

  // Behavioural reference state
  int mv [2][SETS][WAYS], mtag [2][SETS][WAYS], mrd [2][SETS][WAYS];
  int mwr [2][SETS][WAYS], mtot [2][SETS][WAYS];
  int mph = 0, mbusy = 0, mwset = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mk(input int tag, input int set, input int off);
    return (tag << 14) | (set << 12) | off;
  endfunction

  function automatic int eff(input int k, input int s, input int w);
    return (mv[k][s][w] != 0) ? mtot[k][s][w] : 0;
  endfunction

  function automatic int inc(input int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  always @(posedge clk) begin
    int ni, mi, t, s, k, hw, fire, tmp, div;
    if (!rst_n) begin
      foreach (mv[a, b, c]) begin
        mv[a][b][c] = 0; mtag[a][b][c] = 0; mrd[a][b][c] = 0;
        mwr[a][b][c] = 0; mtot[a][b][c] = 0;
      end
      mph = 0; mbusy = 0; mwset = 0;
    end else if (mbusy != 0) begin
      ni = 0; mi = 0;
      for (int w = 1; w < WAYS; w++) begin
        if (eff(0, mwset, w) > eff(0, mwset, ni)) ni = w;
        if (eff(1, mwset, w) < eff(1, mwset, mi)) mi = w;
      end
      if (eff(0, mwset, ni) > eff(1, mwset, mi)) begin
        tmp = mv[0][mwset][ni];   mv[0][mwset][ni]   = mv[1][mwset][mi];   mv[1][mwset][mi]   = tmp;
        tmp = mtag[0][mwset][ni]; mtag[0][mwset][ni] = mtag[1][mwset][mi]; mtag[1][mwset][mi] = tmp;
        tmp = mrd[0][mwset][ni];  mrd[0][mwset][ni]  = mrd[1][mwset][mi];  mrd[1][mwset][mi]  = tmp;
        tmp = mwr[0][mwset][ni];  mwr[0][mwset][ni]  = mwr[1][mwset][mi];  mwr[1][mwset][mi]  = tmp;
        tmp = mtot[0][mwset][ni]; mtot[0][mwset][ni] = mtot[1][mwset][mi]; mtot[1][mwset][mi] = tmp;
      end
      if (mwset == SETS - 1) mbusy = 0;
      mwset = (mwset + 1) % SETS;
    end else if (swap_start) begin
      mbusy = 1; mwset = 0;
    end else if (age_start) begin
      foreach (mv[a, b, c]) begin
        mrd[a][b][c] = mrd[a][b][c] / 2;
        mwr[a][b][c] = mwr[a][b][c] / 2;
        mtot[a][b][c] = mtot[a][b][c] / 2;
      end
    end else if (acc_valid) begin
      div = int'(sample_div);
      fire = (div <= 1 || mph == 0) ? 1 : 0;
      mph = (div <= 1 || mph + 1 >= div) ? 0 : mph + 1;
      if (fire != 0) begin
        s = int'(acc_addr[13:12]);
        t = int'(acc_addr[31:14]);
        k = -1; hw = 0;
        for (int st = 1; st >= 0; st--)
          for (int w = 0; w < WAYS; w++)
            if (k < 0 && mv[st][s][w] != 0 && mtag[st][s][w] == t) begin k = st; hw = w; end
        if (k >= 0) begin
          if (acc_write) mwr[k][s][hw] = inc(mwr[k][s][hw]);
          else           mrd[k][s][hw] = inc(mrd[k][s][hw]);
          mtot[k][s][hw] = inc(mtot[k][s][hw]);
        end else begin
          hw = 0;
          for (int w = 1; w < WAYS; w++) if (eff(0, s, w) < eff(0, s, hw)) hw = w;
          mv[0][s][hw] = 1; mtag[0][s][hw] = t;
          mrd[0][s][hw] = acc_write ? 0 : 1;
          mwr[0][s][hw] = acc_write ? 1 : 0;
          mtot[0][s][hw] = 1;
        end
      end
    end
  end

  // Every-cycle comparison against the model, with a rotating scan address
  always @(negedge clk) begin
    int st, s, w, ev, er;
    #1;
    if (!done_f) begin
      st = int'(scan_store); s = int'(scan_set); w = int'(scan_way);
      er = (mbusy == 0 && !swap_start && !age_start) ? 1 : 0;
      ev = mv[st][s][w];
      chk(int'(busy) == mbusy, "R6 busy vs model", int'(busy), mbusy);
      chk(int'(acc_ready) == er, "R9 ready vs model", int'(acc_ready), er);
      chk(int'(scan_valid) == ev, "R10 valid vs model", int'(scan_valid), ev);
      chk(int'(scan_tag) == mtag[st][s][w], "R10 tag vs model", int'(scan_tag), mtag[st][s][w]);
      chk(int'(scan_rd) == mrd[st][s][w], "R10 rd vs model", int'(scan_rd), mrd[st][s][w]);
      chk(int'(scan_wr) == mwr[st][s][w], "R10 wr vs model", int'(scan_wr), mwr[st][s][w]);
      chk(int'(scan_tot) == mtot[st][s][w], "R10 tot vs model", int'(scan_tot), mtot[st][s][w]);
      chk(int'(scan_hot) == ((ev != 0 && mtot[st][s][w] >= int'(hot_thresh)) ? 1 : 0),
          "R10 hot vs model", int'(scan_hot), int'(ev != 0 && mtot[st][s][w] >= int'(hot_thresh)));
      if (!hold) begin
        si = (si + 1) % 16;
        scan_store = si[3]; scan_set = si[2:1]; scan_way = si[0];
      end
    end
  end

  task automatic acc(input bit wr, input int addr);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_addr = addr;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic probe(input int st, input int s, input int w, input int ev, input int et,
                       input int erd, input int ewr, input int etot, input string req);
    hold = 1;
    @(negedge clk);
    scan_store = st[0]; scan_set = s[1:0]; scan_way = w[0];
    #2;
    chk(int'(scan_valid) == ev, req, int'(scan_valid), ev);
    chk(int'(scan_tag) == et, req, int'(scan_tag), et);
    chk(int'(scan_rd) == erd, req, int'(scan_rd), erd);
    chk(int'(scan_wr) == ewr, req, int'(scan_wr), ewr);
    chk(int'(scan_tot) == etot, req, int'(scan_tot), etot);
    hold = 0;
  endtask

  task automatic run_swap(output int n);
    @(negedge clk); swap_start = 1;
    @(negedge clk); swap_start = 0;
    n = 0;
    #2;
    while (busy) begin n++; @(negedge clk); #2; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    probe(0, 0, 0, 0, 0, 0, 0, 0, "R11 empty after reset");
    chk(busy == 0, "R11 busy low", int'(busy), 0);
    chk(acc_ready == 1, "R11 ready high", int'(acc_ready), 1);

    acc(0, mk(1, 0, 'h010));
    probe(0, 0, 0, 1, 1, 1, 0, 1, "R3 first insert");
    acc(1, mk(1, 0, 'hFFF));
    probe(0, 0, 0, 1, 1, 1, 1, 2, "R1 R2 offset ignored, write hit");
    acc(0, mk(2, 0, 0));
    probe(0, 0, 1, 1, 2, 1, 0, 1, "R3 empty way taken");
    acc(0, mk(3, 0, 0));
    probe(0, 0, 1, 1, 3, 1, 0, 1, "R3 least-count victim");
    probe(0, 0, 0, 1, 1, 1, 1, 2, "R3 busier way kept");
    acc(0, mk(1, 1, 0));
    probe(0, 1, 0, 1, 1, 1, 0, 1, "R1 set index separates");

    run_swap(n);
    chk(n == SETS, "R6 walk length", n, SETS);
    probe(1, 0, 0, 1, 1, 1, 1, 2, "R7 promoted into empty mature way");
    probe(0, 0, 0, 0, 0, 0, 0, 0, "R7 nursery slot vacated");
    probe(1, 1, 0, 1, 1, 1, 0, 1, "R7 promoted in set 1");

    acc(1, mk(1, 0, 'h20));
    probe(1, 0, 0, 1, 1, 1, 2, 3, "R2 mature write hit");
    hot_thresh = 6'd3; #0.5;
    chk(scan_hot == 1, "R10 hot at threshold", int'(scan_hot), 1);
    hot_thresh = 6'd4; #0.5;
    chk(scan_hot == 0, "R10 not hot below threshold", int'(scan_hot), 0);

    @(negedge clk); age_start = 1;
    @(negedge clk); age_start = 0;
    probe(1, 0, 0, 1, 1, 0, 1, 1, "R8 halved");
    probe(0, 0, 1, 1, 3, 0, 0, 0, "R8 valid and tag kept");

    for (int i = 0; i < 70; i++) acc(0, mk(3, 0, 5));
    probe(0, 0, 1, 1, 3, MAXC, 0, MAXC, "R4 saturation");

    sample_div = 4'd3;
    for (int i = 0; i < 3; i++) acc(0, mk(5, 2, 0));
    probe(0, 2, 0, 1, 5, 1, 0, 1, "R5 two skipped");
    acc(0, mk(5, 2, 0));
    probe(0, 2, 0, 1, 5, 2, 0, 2, "R5 third later counted");

    @(negedge clk); swap_start = 1;
    @(negedge clk); swap_start = 0; age_start = 1;
    acc_valid = 1; acc_write = 1; acc_addr = mk(1, 0, 0);
    #2;
    chk(acc_ready == 0, "R9 ready low while busy", int'(acc_ready), 1'b0);
    @(negedge clk); age_start = 0; acc_valid = 0;
    #2;
    while (busy) begin @(negedge clk); #2; end
    probe(1, 0, 0, 1, 1, 0, 1, 1, "R8 R9 ignored while busy");
    probe(1, 0, 1, 1, 3, MAXC, 0, MAXC, "R7 quietest mature way replaced");
    probe(1, 2, 0, 1, 5, 2, 0, 2, "R7 promoted in set 2");

    sample_div = 4'd1;
    acc(0, mk(6, 0, 0));
    probe(0, 0, 0, 1, 6, 1, 0, 1, "R3 vacated way reused");
    run_swap(n);
    chk(n == SETS, "R6 walk length again", n, SETS);
    probe(0, 0, 0, 1, 6, 1, 0, 1, "R7 equal count stays");
    probe(1, 0, 0, 1, 1, 0, 1, 1, "R7 mature entry kept");

    repeat (2) @(negedge clk);
    done_f = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_f) begin
      done_f = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule